// File: doc/BRIEF.md
# Vertical-First Remapped Element Sequencer

This block executes vector arithmetic one element at a time over a small register file of 32-bit words. Each step command performs a single element of an add, xor or rotate-left. Software chooses whether the element counter advances after that step. The register numbers come from loadable index tables rather than from the element number. A small remap register picks which table feeds the destination, the first source and the second source. A separate four-entry table holds rotate amounts, and the element counter modulo 4 selects among them.

Because the counter can hold across several commands, a sequence such as add, xor, rotate can run on one element before moving to the next. This is vertical-first order: each element goes through the whole sequence rather than each operation sweeping the whole vector. With tables laid out as quarter-round operand lists, one 32-element vector forms a column round plus a diagonal round of the familiar add-rotate-xor permutation.

The register file is stored as 64-bit rows, two words to a row. All arithmetic is 32-bit. All pins are plain control and data: there is no streaming interface, so no back-pressure applies.

Top module: `vfs_sequencer`

## Requirements
- R1: A synchronous reset sets the element counter to 0, clears `vec_end` and sets all three remap selectors to 0 (table 0). Index tables, the rotate table and the register file keep their contents through reset.
- R2: A cycle with `step` high writes one result word into the register file at that clock edge. The new value is visible on `rd_data` in the following cycle.
- R3: `step_op` encoding: 0 is a 32-bit add modulo 2^32, 1 is xor, 2 rotates source A left by the rotate-table entry at (element mod 4), and 3 copies source A.
- R4: A step with `step_last` high advances the element counter by one. A step with `step_last` low leaves it unchanged, and so does a cycle without a step. After element VLEN-1 the counter wraps to 0.
- R5: `vec_end` is high for exactly the one cycle that follows the step that wraps the counter.
- R6: `cfg_we` loads the remap register: bits [1:0] select the destination source, [3:2] source A and [5:4] source B. Selector values 0 to 2 pick index table 0 to 2 at the current element, and value 3 uses the element number itself as the word index. A step in the same cycle still uses the previous remap.
- R7: `tbl_we` with `tbl_sel` 0 to 2 writes `tbl_data` into that index table at entry `tbl_addr`. With `tbl_sel` 3 it writes `tbl_data[4:0]` into rotate entry `tbl_addr[1:0]`.
- R8: Only the low log2(NWORDS) bits of an index entry address the register file. The upper bits of the entry have no effect.
- R9: Word w lives in row w>>1, in the low half when w[0] is 0 and in the high half otherwise. Writing one word leaves its row partner unchanged. `wr_en` writes `wr_data` into word `wr_word`.
- R10: When `step` and `wr_en` are both high in a cycle, only the step result is written and the external write is dropped.
- R11: With quarter-round operand tables (add: dst/A table 0, B table 1; xor: dst/A table 2, B table 0; rotate: dst/A table 2, amounts 16,12,8,7), ten vectors of add, xor, rotate per element yield the 20-round permutation of the initial 16 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | External register-file write |
| wr_word | input | 4 | Word index for external write |
| wr_data | input | 32 | External write data |
| rd_word | input | 4 | Word index for readout |
| rd_data | output | 32 | Combinational readout of `rd_word` |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 2 | Table select: 0-2 index tables, 3 rotate table |
| tbl_addr | input | 5 | Table entry |
| tbl_data | input | 8 | Table entry value |
| cfg_we | input | 1 | Remap register write |
| cfg_data | input | 6 | Remap selectors {B, A, dst} |
| step | input | 1 | Execute one element |
| step_op | input | 2 | Operation of this step |
| step_last | input | 1 | Advance the element counter after this step |
| elem_idx | output | 5 | Current element number |
| vec_end | output | 1 | Pulse after the counter wraps |

## Verification
The bench builds the block at its defaults: 32 elements, 16 words and 8-bit index entries. At this size a full vector reaches the wrap and the `vec_end` pulse ten times. Because index entries are wider than the word address, upper-bit entries can show that they alias to low words. A behavioural model tracks every step and is compared on each one. An independent quarter-round routine then confirms the final state after twenty rounds. A directed tail covers coinciding writes, the element-number selector, the copy operation and table retention across reset.

// File: rtl/vfs_pkg.sv
package vfs_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_XOR  = 2'd1,
    OP_ROTL = 2'd2,
    OP_MOVE = 2'd3
  } vfs_op_e;

  typedef enum logic [1:0] {
    SRC_T0   = 2'd0,
    SRC_T1   = 2'd1,
    SRC_T2   = 2'd2,
    SRC_ELEM = 2'd3
  } vfs_src_e;

  // packed: b in [5:4], a in [3:2], d in [1:0]
  typedef struct packed {
    vfs_src_e b;
    vfs_src_e a;
    vfs_src_e d;
  } vfs_remap_t;
endpackage

// File: rtl/vfs_index_tables.sv
module vfs_index_tables #(
  parameter int VLEN  = 32,
  parameter int IDX_W = 8,
  parameter int ROT_N = 4
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [1:0]                sel,
  input  logic [$clog2(VLEN)-1:0]   addr,
  input  logic [IDX_W-1:0]          data,
  input  logic [$clog2(VLEN)-1:0]   rd_elem,
  output logic [2:0][IDX_W-1:0]     idx_o,
  output logic [4:0]                rot_o
);
  localparam int RW = $clog2(ROT_N);

  for (genvar t = 0; t < 3; t++) begin : g_tbl
    logic [IDX_W-1:0] ent [VLEN];
    always_ff @(posedge clk) begin
      if (we && sel == 2'(t)) ent[addr] <= data;
    end
    assign idx_o[t] = ent[rd_elem];
  end

  logic [4:0] rot_ent [ROT_N];
  always_ff @(posedge clk) begin
    if (we && sel == 2'd3) rot_ent[addr[RW-1:0]] <= data[4:0];
  end
  assign rot_o = rot_ent[rd_elem[RW-1:0]];
endmodule

// File: rtl/vfs_regfile.sv
module vfs_regfile #(
  parameter int NWORDS = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [$clog2(NWORDS)-1:0] waddr,
  input  logic [31:0]               wdata,
  input  logic [$clog2(NWORDS)-1:0] ra,
  input  logic [$clog2(NWORDS)-1:0] rb,
  input  logic [$clog2(NWORDS)-1:0] rx,
  output logic [31:0]               qa,
  output logic [31:0]               qb,
  output logic [31:0]               qx
);
  localparam int WA    = $clog2(NWORDS);
  localparam int NROWS = NWORDS / 2;

  logic [63:0] mem [NROWS];

  always_ff @(posedge clk) begin
    if (we) begin
      if (waddr[0]) mem[waddr[WA-1:1]][63:32] <= wdata;
      else          mem[waddr[WA-1:1]][31:0]  <= wdata;
    end
  end

  assign qa = ra[0] ? mem[ra[WA-1:1]][63:32] : mem[ra[WA-1:1]][31:0];
  assign qb = rb[0] ? mem[rb[WA-1:1]][63:32] : mem[rb[WA-1:1]][31:0];
  assign qx = rx[0] ? mem[rx[WA-1:1]][63:32] : mem[rx[WA-1:1]][31:0];

  // partner-half capture for checking
  logic          chk_valid;
  logic [WA-1:0] chk_partner;
  logic [31:0]   chk_val;
  logic [WA-1:0] partner_now;
  assign partner_now = waddr ^ WA'(1);
  always_ff @(posedge clk) begin
    if (rst) chk_valid <= 1'b0;
    else     chk_valid <= we;
    chk_partner <= partner_now;
    chk_val     <= partner_now[0] ? mem[partner_now[WA-1:1]][63:32]
                                  : mem[partner_now[WA-1:1]][31:0];
  end

  assert_partner_kept_R9: assert property (@(posedge clk) disable iff (rst)
    chk_valid |-> ((chk_partner[0] ? mem[chk_partner[WA-1:1]][63:32]
                                   : mem[chk_partner[WA-1:1]][31:0]) == chk_val));
endmodule

// File: rtl/vfs_alu.sv
module vfs_alu
  import vfs_pkg::*;
(
  input  vfs_op_e     op,
  input  logic [31:0] a,
  input  logic [31:0] b,
  input  logic [4:0]  amt,
  output logic [31:0] y
);
  logic [5:0] back;
  assign back = 6'd32 - {1'b0, amt};

  always_comb begin
    unique case (op)
      OP_ADD:  y = a + b;
      OP_XOR:  y = a ^ b;
      OP_ROTL: y = (a << amt) | (a >> back);
      default: y = a;
    endcase
  end
endmodule

// File: rtl/vfs_sequencer.sv
module vfs_sequencer
  import vfs_pkg::*;
#(
  parameter int VLEN   = 32,
  parameter int NWORDS = 16,
  parameter int IDX_W  = 8,
  parameter int ROT_N  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [$clog2(NWORDS)-1:0] wr_word,
  input  logic [31:0]               wr_data,
  input  logic [$clog2(NWORDS)-1:0] rd_word,
  output logic [31:0]               rd_data,
  input  logic                      tbl_we,
  input  logic [1:0]                tbl_sel,
  input  logic [$clog2(VLEN)-1:0]   tbl_addr,
  input  logic [IDX_W-1:0]          tbl_data,
  input  logic                      cfg_we,
  input  logic [5:0]                cfg_data,
  input  logic                      step,
  input  logic [1:0]                step_op,
  input  logic                      step_last,
  output logic [$clog2(VLEN)-1:0]   elem_idx,
  output logic                      vec_end
);
  localparam int EW = $clog2(VLEN);
  localparam int WA = $clog2(NWORDS);
  localparam logic [EW-1:0] LAST = EW'(VLEN - 1);

  logic [EW-1:0] elem_q;
  logic          vec_end_q;
  vfs_remap_t    cfg_q;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (cfg_we) cfg_q <= vfs_remap_t'(cfg_data);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      elem_q    <= '0;
      vec_end_q <= 1'b0;
    end else begin
      vec_end_q <= 1'b0;
      if (step && step_last) begin
        if (elem_q == LAST) begin
          elem_q    <= '0;
          vec_end_q <= 1'b1;
        end else begin
          elem_q <= elem_q + 1'b1;
        end
      end
    end
  end

  logic [2:0][IDX_W-1:0] tbl_idx;
  logic [4:0]            rot_amt;

  vfs_index_tables #(.VLEN(VLEN), .IDX_W(IDX_W), .ROT_N(ROT_N)) u_tables (
    .clk(clk), .we(tbl_we), .sel(tbl_sel), .addr(tbl_addr), .data(tbl_data),
    .rd_elem(elem_q), .idx_o(tbl_idx), .rot_o(rot_amt)
  );

  function automatic logic [WA-1:0] resolve(input vfs_src_e s,
                                            input logic [2:0][IDX_W-1:0] ix,
                                            input logic [EW-1:0] e);
    logic [WA-1:0] r;
    unique case (s)
      SRC_T0:  r = ix[0][WA-1:0];
      SRC_T1:  r = ix[1][WA-1:0];
      SRC_T2:  r = ix[2][WA-1:0];
      default: r = WA'(e);
    endcase
    return r;
  endfunction

  logic [WA-1:0] d_word, a_word, b_word;
  assign d_word = resolve(cfg_q.d, tbl_idx, elem_q);
  assign a_word = resolve(cfg_q.a, tbl_idx, elem_q);
  assign b_word = resolve(cfg_q.b, tbl_idx, elem_q);

  logic idx_hi_unused;
  assign idx_hi_unused = ^{tbl_idx[0][IDX_W-1:WA], tbl_idx[1][IDX_W-1:WA],
                           tbl_idx[2][IDX_W-1:WA]};

  logic [31:0] a_val, b_val, alu_y;
  logic        rf_we;
  logic [WA-1:0] rf_waddr;
  logic [31:0] rf_wdata;

  assign rf_we    = step | wr_en;
  assign rf_waddr = step ? d_word : wr_word;
  assign rf_wdata = step ? alu_y  : wr_data;

  vfs_regfile #(.NWORDS(NWORDS)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .ra(a_word), .rb(b_word), .rx(rd_word),
    .qa(a_val), .qb(b_val), .qx(rd_data)
  );

  vfs_alu u_alu (
    .op(vfs_op_e'(step_op)), .a(a_val), .b(b_val), .amt(rot_amt), .y(alu_y)
  );

  assign elem_idx = elem_q;
  assign vec_end  = vec_end_q;

  assert_advance_R4: assert property (@(posedge clk) disable iff (rst)
    (step && step_last && elem_q != LAST) |=> elem_q == $past(elem_q) + 1'b1);

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !(step && step_last) |=> $stable(elem_q));

  assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (step && step_last && elem_q == LAST) |=> (elem_q == '0 && vec_end_q));

  assert_vec_end_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(vec_end_q) |-> $past(step && step_last));

  assert_cfg_stable_R6: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(cfg_q));
endmodule

// File: tb/vfs_sequencer_test.sv
module vfs_sequencer_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst, wr_en, tbl_we, cfg_we, step, step_last;
  logic [3:0]  wr_word, rd_word;
  logic [31:0] wr_data, rd_data;
  logic [1:0]  tbl_sel, step_op;
  logic [4:0]  tbl_addr, elem_idx;
  logic [7:0]  tbl_data;
  logic [5:0]  cfg_data;
  logic        vec_end;

  vfs_sequencer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data),
    .rd_word(rd_word), .rd_data(rd_data), .tbl_we(tbl_we), .tbl_sel(tbl_sel),
    .tbl_addr(tbl_addr), .tbl_data(tbl_data), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .step(step), .step_op(step_op), .step_last(step_last),
    .elem_idx(elem_idx), .vec_end(vec_end)
  );

  int total = 0, failed = 0;
  bit done = 0;

  // behavioural model
  int          mtbl [3][32];
  int          mrot [4];
  logic [31:0] mreg [16];
  int          melem = 0;
  int          md = 0, ma = 0, mb = 0;
  logic [31:0] cref [16];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rotl(input logic [31:0] x, input int n);
    return n == 0 ? x : ((x << n) | (x >> (32 - n)));
  endfunction

  function automatic int word_of(input int s, input int e);
    return (s == 3) ? (e % 16) : (mtbl[s][e] % 16);
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    melem = 0; md = 0; ma = 0; mb = 0;
  endtask

  task automatic load_word(input int w, input logic [31:0] v);
    @(negedge clk); wr_en = 1; wr_word = 4'(w); wr_data = v;
    @(negedge clk); wr_en = 0;
    mreg[w] = v;
  endtask

  task automatic load_tbl(input int s, input int a, input int v);
    @(negedge clk); tbl_we = 1; tbl_sel = 2'(s); tbl_addr = 5'(a); tbl_data = 8'(v);
    @(negedge clk); tbl_we = 0;
    if (s == 3) mrot[a % 4] = v % 32; else mtbl[s][a] = v;
  endtask

  task automatic set_cfg(input int d, input int a, input int b);
    @(negedge clk); cfg_we = 1; cfg_data = {2'(b), 2'(a), 2'(d)};
    @(negedge clk); cfg_we = 0;
    md = d; ma = a; mb = b;
  endtask

  task automatic read_chk(input int w, input logic [31:0] exp, input string req);
    @(negedge clk); rd_word = 4'(w);
    #1 chk(rd_data === exp, req, rd_data, exp);
  endtask

  // one step; checks written word, counter and vec_end in the next cycle
  task automatic do_step(input int op, input bit last, input string req);
    int d, a, b; logic [31:0] y; bit wrap;
    d = word_of(md, melem); a = word_of(ma, melem); b = word_of(mb, melem);
    case (op)
      0: y = mreg[a] + mreg[b];
      1: y = mreg[a] ^ mreg[b];
      2: y = rotl(mreg[a], mrot[melem % 4]);
      default: y = mreg[a];
    endcase
    mreg[d] = y;
    wrap = last && (melem == 31);
    if (last) melem = (melem + 1) % 32;
    @(negedge clk); step = 1; step_op = 2'(op); step_last = last; rd_word = 4'(d);
    @(negedge clk); step = 0;
    chk(rd_data === mreg[d], req, rd_data, mreg[d]);
    chk(elem_idx === 5'(melem), "R4 counter", 32'(elem_idx), 32'(melem));
    chk(vec_end === wrap, "R5 vec_end", 32'(vec_end), 32'(wrap));
  endtask

  task automatic cqr(input int a, input int b, input int c, input int d);
    cref[a] = cref[a] + cref[b]; cref[d] = rotl(cref[d] ^ cref[a], 16);
    cref[c] = cref[c] + cref[d]; cref[b] = rotl(cref[b] ^ cref[c], 12);
    cref[a] = cref[a] + cref[b]; cref[d] = rotl(cref[d] ^ cref[a], 8);
    cref[c] = cref[c] + cref[d]; cref[b] = rotl(cref[b] ^ cref[c], 7);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  int qrs [8][4] = '{'{0,4,8,12}, '{1,5,9,13}, '{2,6,10,14}, '{3,7,11,15},
                     '{0,5,10,15}, '{1,6,11,12}, '{2,7,8,13}, '{3,4,9,14}};

  initial begin
    rst = 1; wr_en = 0; tbl_we = 0; cfg_we = 0; step = 0; step_last = 0;
    wr_word = 0; rd_word = 0; wr_data = 0; tbl_sel = 0; tbl_addr = 0;
    tbl_data = 0; cfg_data = 0; step_op = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    chk(elem_idx === 5'd0, "R1 reset counter", 32'(elem_idx), 0);
    chk(vec_end === 1'b0, "R1 reset vec_end", 32'(vec_end), 0);

    // R9: load words, each write keeps its partner
    for (int w = 0; w < 16; w++) load_word(w, 32'h9e3779b9 * (w + 1) ^ 32'(w << 20));
    for (int w = 0; w < 16; w++) read_chk(w, mreg[w], "R9 word layout");
    for (int w = 0; w < 16; w++) cref[w] = mreg[w];

    // R7: quarter-round tables
    for (int q = 0; q < 8; q++)
      for (int s = 0; s < 4; s++) begin
        load_tbl(0, q*4+s, (s % 2 == 0) ? qrs[q][0] : qrs[q][2]);
        load_tbl(1, q*4+s, (s % 2 == 0) ? qrs[q][1] : qrs[q][3]);
        load_tbl(2, q*4+s, (s % 2 == 0) ? qrs[q][3] : qrs[q][1]);
      end
    load_tbl(3, 0, 16); load_tbl(3, 1, 12); load_tbl(3, 2, 8); load_tbl(3, 3, 7);

    // R2, R3, R4, R5, R6: ten vectors, vertical-first
    for (int v = 0; v < 10; v++)
      for (int e = 0; e < 32; e++) begin
        set_cfg(0, 0, 1); do_step(0, 0, "R3 add");
        set_cfg(2, 2, 0); do_step(1, 0, "R3 xor");
        set_cfg(2, 2, 2); do_step(2, 1, "R2 rotate");
      end

    // R11: independent 20-round permutation
    for (int r = 0; r < 10; r++)
      for (int q = 0; q < 8; q++) cqr(qrs[q][0], qrs[q][1], qrs[q][2], qrs[q][3]);
    for (int w = 0; w < 16; w++) read_chk(w, cref[w], "R11 permutation");

    // R8: upper index bits ignored (0x13 -> word 3, 0x25 -> word 5)
    load_tbl(0, 0, 8'h13); load_tbl(1, 0, 8'h25);
    set_cfg(0, 0, 1); do_step(0, 0, "R8 high bits");

    // R10: step wins over coinciding external write to word 15
    begin
      int d; d = word_of(md, melem);
      mreg[d] = mreg[word_of(ma, melem)] + mreg[word_of(mb, melem)];
      @(negedge clk); step = 1; step_op = 0; step_last = 0;
      wr_en = 1; wr_word = 4'd15; wr_data = 32'hdeadbeef;
      @(negedge clk); step = 0; wr_en = 0;
      read_chk(d, mreg[d], "R10 step result");
      read_chk(15, mreg[15], "R10 dropped write");
    end

    // R6: element-number selector; R3: copy op
    set_cfg(3, 3, 3); do_step(1, 1, "R6 element selector");
    set_cfg(3, 1, 0); do_step(3, 0, "R3 copy");
    // R6: remap write alongside step uses old remap
    begin
      int d; d = word_of(md, melem);
      mreg[d] = mreg[word_of(ma, melem)];
      @(negedge clk); step = 1; step_op = 3; step_last = 0;
      cfg_we = 1; cfg_data = 6'b000000;
      @(negedge clk); step = 0; cfg_we = 0;
      md = 0; ma = 0; mb = 0;
      read_chk(d, mreg[d], "R6 same-cycle remap");
    end

    // R1: reset clears counter and remap, tables survive
    do_reset();
    #1 chk(elem_idx === 5'd0, "R1 reset counter", 32'(elem_idx), 0);
    do_step(0, 0, "R1 remap cleared, tables kept");

    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule